// File: doc/BRIEF.md
# Isochronous Cycle Timer

This block holds the 32-bit cycle-time register of a serial-bus node. It runs in the 24.576 MHz clock domain. The register has three fields. The low field counts clock ticks within a 125 µs cycle, the middle field counts cycles, and the top field counts seconds. Each time the cycle count advances, the block emits a one-clock pulse on `cycle_out`.

The cycle count can advance from one of two sources. In the first, the tick field rolls over on its own. In the second, which is meant for the cycle master, an external 8 kHz input steps the count. A non-master node overwrites the whole register with the time carried in a received cycle-start packet. A host can read and write the register at local address 0x14.

Top module: `iso_cycle_timer`

## Requirements
- R1: After reset, `time_q` is zero and `cycle_out` is low.
- R2: When `ext_src` is 0 and `enable` is 1, the tick field `time_q[11:0]` increases by one on every clock. After 3071 it returns to 0. In that same edge the cycle field `time_q[24:12]` increases by one, and `cycle_out` is high for exactly the one cycle in which the new cycle value is first visible.
- R3: The cycle field counts 0 to 7999. After 7999 it returns to 0 and adds one to the seconds field `time_q[31:25]`. The seconds field returns to 0 after 127.
- R4: When `ext_src` is 1, the `cyc_in` input passes through a two-flop synchronizer and then a rising-edge detector.
  - A rising edge on `cyc_in` increments the cycle field on the third rising clock edge after the input rises. In that same edge the tick field becomes 0 and `cycle_out` pulses.
  - A level of `cyc_in` that stays high does not step the count again.
  - In this mode a rollover of the tick field returns it to 0 without changing the cycle field.
- R5: While `enable` is 0, `time_q` holds and `cycle_out` stays low. Loads from the host and from packets still take effect.
- R6: When `pkt_load` is 1, `time_q` takes `pkt_time` at the next edge and `cycle_out` stays low.
- R7: A write with `host_we` = 1 and `host_addr` = 0x14 loads `host_wdata` into `time_q` at the next edge. A write to any other address leaves the count running normally.
- R8: `host_rdata` equals `time_q` when `host_addr` is 0x14 and is zero otherwise. It is combinational.
- R9: When a host write to 0x14 and a `pkt_load` arrive in the same clock, the host value is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 24.576 MHz tick clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Timer run enable |
| ext_src | input | 1 | 1: the external cycle input steps the cycle count |
| cyc_in | input | 1 | External 8 kHz cycle input, asynchronous |
| pkt_load | input | 1 | Reload strobe from a received cycle-start packet |
| pkt_time | input | 32 | Time value carried in the cycle-start packet |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host local address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| time_q | output | 32 | Cycle-time register |
| cycle_out | output | 1 | One-clock pulse on each cycle-count increment |

## Verification
The same-clock cases that matter are these:
- A host write can meet a packet reload in one clock.
- An internal tick rollover can arrive in the same clock as a load.

The bench provokes the first case by raising `host_we` and `pkt_load` together with different values. It judges the result by requiring the host value in `time_q` at the next sample, with `cycle_out` low.

For the second case, the bench loads a tick value of 3071 and then issues the reload on the following clock. The reloaded value must appear unchanged and no cycle pulse may appear.

// File: rtl/iso_cycle_timer.sv
module iso_cycle_timer #(
  parameter int OFS_W    = 12,
  parameter int CNT_W    = 13,
  parameter int SEC_W    = 7,
  parameter int OFS_MOD  = 3072,
  parameter int CNT_MOD  = 8000,
  parameter int AW       = 8,
  parameter logic [7:0] REG_ADDR = 8'h14,
  localparam int TW      = OFS_W + CNT_W + SEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          ext_src,
  input  logic          cyc_in,
  input  logic          pkt_load,
  input  logic [TW-1:0] pkt_time,
  input  logic          host_we,
  input  logic [AW-1:0] host_addr,
  input  logic [TW-1:0] host_wdata,
  output logic [TW-1:0] host_rdata,
  output logic [TW-1:0] time_q,
  output logic          cycle_out
);
  logic [OFS_W-1:0] ofs;
  logic [CNT_W-1:0] cnt;
  logic [SEC_W-1:0] sec;
  logic [2:0]       sync;

  wire addr_hit = host_addr == AW'(REG_ADDR);
  wire wr_hit   = host_we && addr_hit;
  wire ofs_last = ofs >= OFS_W'(OFS_MOD - 1);
  wire cnt_last = cnt >= CNT_W'(CNT_MOD - 1);
  wire ext_edge = sync[1] & ~sync[2];
  wire step     = ext_src ? ext_edge : ofs_last;

  assign time_q     = {sec, cnt, ofs};
  assign host_rdata = addr_hit ? time_q : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], cyc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs       <= '0;
      cnt       <= '0;
      sec       <= '0;
      cycle_out <= 1'b0;
    end else if (wr_hit) begin
      {sec, cnt, ofs} <= host_wdata;
      cycle_out       <= 1'b0;
    end else if (pkt_load) begin
      {sec, cnt, ofs} <= pkt_time;
      cycle_out       <= 1'b0;
    end else if (enable) begin
      ofs <= (ofs_last || (ext_src && ext_edge)) ? '0 : ofs + 1'b1;
      if (step) begin
        cnt <= cnt_last ? '0 : cnt + 1'b1;
        if (cnt_last) sec <= sec + 1'b1;
      end
      cycle_out <= step;
    end else begin
      cycle_out <= 1'b0;
    end
  end
endmodule

// File: rtl/iso_cycle_timer_chk.sv
module iso_cycle_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        enable,
  input logic        ext_src,
  input logic        pkt_load,
  input logic [31:0] pkt_time,
  input logic        host_we,
  input logic [7:0]  host_addr,
  input logic [31:0] host_wdata,
  input logic [31:0] time_q,
  input logic        cycle_out
);
  wire wr_hit = host_we && host_addr == 8'h14;

  // R2
  ofs_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !ext_src && !wr_hit && !pkt_load && time_q[11:0] < 12'd3071)
    |=> time_q[11:0] == $past(time_q[11:0]) + 12'd1);

  // R2
  pulse_moves_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_out |-> time_q[24:12] != $past(time_q[24:12]));

  // R5
  frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !wr_hit && !pkt_load) |=> ($stable(time_q) && !cycle_out));

  // R9
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> time_q == $past(host_wdata));

  // R6
  pkt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_load && !wr_hit) |=> (time_q == $past(pkt_time) && !cycle_out));
endmodule

bind iso_cycle_timer iso_cycle_timer_chk chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .ext_src(ext_src),
  .pkt_load(pkt_load), .pkt_time(pkt_time), .host_we(host_we),
  .host_addr(host_addr), .host_wdata(host_wdata), .time_q(time_q),
  .cycle_out(cycle_out)
);

// File: tb/tb_iso_cycle_timer.sv
module tb_iso_cycle_timer;
  logic clk = 0, rst_n = 0, enable = 0, ext_src = 0, cyc_in = 0;
  logic pkt_load = 0, host_we = 0;
  logic [31:0] pkt_time = '0, host_wdata = '0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_rdata, time_q;
  logic        cycle_out;
  int checks = 0, errors = 0;

  typedef struct { logic [31:0] t; logic c; string tag; } item_t;
  item_t q[$];
  item_t it;

  iso_cycle_timer dut (.*);

  always #2 clk = ~clk;

  function automatic logic [31:0] mk(int s, int c, int o);
    return {7'(s), 13'(c), 12'(o)};
  endfunction

  always @(negedge clk) begin
    while (q.size() > 0) begin
      it = q.pop_front();
      checks++;
      if (time_q !== it.t || cycle_out !== it.c) begin
        errors++;
        $display("FAIL %s: time=%h co=%b expected time=%h co=%b", it.tag, time_q, cycle_out, it.t, it.c);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic expect_(logic [31:0] t, logic c, string tag);
    item_t x; x.t = t; x.c = c; x.tag = tag; q.push_back(x);
  endtask

  task automatic hwrite(logic [7:0] a, logic [31:0] d);
    host_we = 1; host_addr = a; host_wdata = d; tick(); host_we = 0; host_addr = 8'h14;
  endtask

  task automatic rd_check(logic [7:0] a, logic [31:0] exp, string tag);
    host_addr = a; #0.5;
    checks++;
    if (host_rdata !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected %h", tag, host_rdata, exp);
    end
    host_addr = 8'h14;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: time=%h expected completion", time_q);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick();
    expect_(32'h0, 0, "R1 reset"); tick();
    rst_n = 1; tick();
    expect_(32'h0, 0, "R1 idle after reset (disabled)"); tick();

    hwrite(8'h14, mk(0, 5, 3070)); expect_(mk(0, 5, 3070), 0, "R7 host load");
    rd_check(8'h14, mk(0, 5, 3070), "R8 read at 0x14");
    rd_check(8'h20, 32'h0, "R8 read elsewhere");
    enable = 1;
    tick(); expect_(mk(0, 5, 3071), 0, "R2 tick advance");
    tick(); expect_(mk(0, 6, 0), 1, "R2 rollover carry");
    tick(); expect_(mk(0, 6, 1), 0, "R2 single pulse");
    hwrite(8'h10, 32'hFFFF_FFFF); expect_(mk(0, 6, 2), 0, "R7 other address ignored");

    hwrite(8'h14, mk(3, 7999, 3071)); expect_(mk(3, 7999, 3071), 0, "R7 load");
    tick(); expect_(mk(4, 0, 0), 1, "R3 cycle wrap into seconds");
    hwrite(8'h14, mk(127, 7999, 3071));
    tick(); expect_(mk(0, 0, 0), 1, "R3 seconds wrap");

    enable = 0;
    hwrite(8'h14, mk(9, 100, 3071)); expect_(mk(9, 100, 3071), 0, "R5 load while disabled");
    tick(); expect_(mk(9, 100, 3071), 0, "R5 hold 1");
    tick(); expect_(mk(9, 100, 3071), 0, "R5 hold 2");
    pkt_load = 1; pkt_time = mk(20, 30, 40); tick(); pkt_load = 0;
    expect_(mk(20, 30, 40), 0, "R6 packet reload while disabled");

    enable = 1;
    hwrite(8'h14, mk(1, 1, 3071));
    pkt_load = 1; pkt_time = mk(2, 2, 2); tick(); pkt_load = 0;
    expect_(mk(2, 2, 2), 0, "R6 reload beats rollover");
    pkt_load = 1; pkt_time = mk(5, 5, 5);
    hwrite(8'h14, mk(6, 6, 6)); pkt_load = 0;
    expect_(mk(6, 6, 6), 0, "R9 host write wins");

    ext_src = 1;
    hwrite(8'h14, mk(0, 10, 3071));
    tick(); expect_(mk(0, 10, 0), 0, "R4 no carry in external mode");
    cyc_in = 1;
    tick(); expect_(mk(0, 10, 1), 0, "R4 sync stage 1");
    tick(); expect_(mk(0, 10, 2), 0, "R4 sync stage 2");
    tick(); expect_(mk(0, 11, 0), 1, "R4 edge steps count");
    tick(); expect_(mk(0, 11, 1), 0, "R4 held level no retrigger");
    tick(); expect_(mk(0, 11, 2), 0, "R4 held level no retrigger");
    cyc_in = 0;
    repeat (4) tick();
    expect_(mk(0, 11, 6), 0, "R4 falling edge ignored");
    tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule